// File: doc/BRIEF.md
# Gated Horizontal Sync Pulse Counter

This block measures the line rate of an incoming video signal. It counts rising edges of the horizontal sync input inside a gate window. At the end of each window it copies the count into a holding register, so that firmware can compare the count against the expected line count for a video mode. The gate window is either the span between two successive vertical sync rising edges, or a fixed window built from an external timebase tick. With a tick period of 1.024 ms, the two fixed windows last 16.384 ms (16 ticks) and 32.768 ms (32 ticks).

The running counter is 14 bits wide and saturates at its maximum. An edge that arrives while the counter is already at its maximum sets a sticky overflow flag. A dedicated clear strobe clears that flag and leaves the running counter untouched. The mode is held in three control bits: a gate-source bit and a two-bit window select. The bits are loaded by a write strobe, and a write that would leave no valid window is refused.

Top module: `hsync_gate_counter`

## Requirements
- R1: After reset, `count_o` is 0, `ovf_o` is 0, `mode_en_o` reads 1 and `mode_sel_o` reads 2'b01.
- R2: While `mode_en_o` is 1, rising edges of `hsync_i` are counted between successive rising edges of `vsync_i`. Each `vsync_i` rising edge copies the count to `count_o`, which otherwise holds its value. `mode_sel_o` has no effect in this mode, and neither does `tick_i`.
- R3: With `mode_en_o` 0 and `mode_sel_o[1]` 0, the gate closes on every 16th `tick_i` pulse, and the count is copied to `count_o` at that point.
- R4: With `mode_en_o` 0 and `mode_sel_o[1]` 1, the gate closes on every 32nd `tick_i` pulse.
- R5: A write (`ctrl_we_i` high) with `ctrl_en_i` 0 and `ctrl_sel_i` 2'b00 is refused, and the mode bits keep their previous values. Every other write is stored.
- R6: At each gate boundary the running counter restarts from zero. An `hsync_i` rising edge in the boundary cycle is counted in the new window.
- R7: The running counter saturates at 16383. An `hsync_i` rising edge that arrives while the counter is at 16383 sets `ovf_o`.
- R8: `ovf_o` stays 1 across gate boundaries until `ovf_clr_i` is pulsed, and the pulse returns it to 0.
- R9: Pulsing `ovf_clr_i` does not reset the running counter.
- R10: A stored write that changes the mode bits restarts the window timer, so the first fixed window after the change is a full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync, synchronous, active high |
| vsync_i | input | 1 | Vertical sync, synchronous, active high |
| tick_i | input | 1 | One-cycle timebase pulse |
| ctrl_we_i | input | 1 | Mode write strobe |
| ctrl_en_i | input | 1 | Gate-source bit to write (1 = vertical-sync gate) |
| ctrl_sel_i | input | 2 | Window select to write (bit 1 picks the long window) |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| count_o | output | 14 | Latched count of the last window |
| ovf_o | output | 1 | Sticky overflow flag |
| mode_en_o | output | 1 | Stored gate-source bit |
| mode_sel_o | output | 2 | Stored window select |

## Verification
The hardest state to reach is an overflow that is followed by a clear in the middle of a window, because the saturated counter must be filled first. The stimulus drives more than 16383 line pulses inside a single vertical-sync window. It then checks that the flag survives the next boundary, and clears the flag between two short bursts of pulses. The count latched at the following boundary shows that the counter kept its bursts across the clear. A second hard case is a mode switch in the middle of a long window. The timer must restart there, while the running count carries over from before the switch.

// File: rtl/hsync_gate_counter.sv
module hsync_gate_counter #(
  parameter int CNT_W       = 14,
  parameter int SHORT_TICKS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             tick_i,
  input  logic             ctrl_we_i,
  input  logic             ctrl_en_i,
  input  logic [1:0]       ctrl_sel_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             mode_en_o,
  output logic [1:0]       mode_sel_o
);
  localparam int LONG_TICKS = 2 * SHORT_TICKS;
  localparam int TMR_W      = $clog2(LONG_TICKS);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [TMR_W-1:0] SHORT_LAST = TMR_W'(SHORT_TICKS - 1);
  localparam logic [TMR_W-1:0] LONG_LAST  = TMR_W'(LONG_TICKS - 1);

  logic             hs_q, vs_q;
  logic             en_q;
  logic [1:0]       sel_q;
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hold_q;
  logic             ovf_q;

  wire hs_rise  = hsync_i & ~hs_q;
  wire vs_rise  = vsync_i & ~vs_q;
  wire wr_ok    = ctrl_we_i & (ctrl_en_i | (ctrl_sel_i != 2'b00));
  wire mode_chg = wr_ok & ({ctrl_en_i, ctrl_sel_i} != {en_q, sel_q});

  wire [TMR_W-1:0] win_last = sel_q[1] ? LONG_LAST : SHORT_LAST;
  wire timer_end = ~en_q & tick_i & (tmr == win_last);
  wire gate_end  = en_q ? vs_rise : timer_end;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hs_q <= hsync_i;
      vs_q <= vsync_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q  <= 1'b1;
      sel_q <= 2'b01;
    end else if (wr_ok) begin
      en_q  <= ctrl_en_i;
      sel_q <= ctrl_sel_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                tmr <= '0;
    else if (mode_chg || en_q)  tmr <= '0;
    else if (tick_i)            tmr <= (tmr == win_last) ? '0 : tmr + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                     cnt <= '0;
    else if (gate_end)               cnt <= hs_rise ? CNT_W'(1) : '0;
    else if (hs_rise && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       hold_q <= '0;
    else if (gate_end) hold_q <= cnt;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                                     ovf_q <= 1'b0;
    else if (hs_rise && !gate_end && cnt == CNT_MAX) ovf_q <= 1'b1;
    else if (ovf_clr_i)                              ovf_q <= 1'b0;
  end

  assign count_o    = hold_q;
  assign ovf_o      = ovf_q;
  assign mode_en_o  = en_q;
  assign mode_sel_o = sel_q;
endmodule

// File: rtl/hsync_gate_counter_chk.sv
module hsync_gate_counter_chk #(
  parameter int CNT_W = 14,
  parameter int TMR_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hsync_i,
  input logic             ovf_clr_i,
  input logic             en_q,
  input logic [1:0]       sel_q,
  input logic             vs_rise,
  input logic             hs_rise,
  input logic             gate_end,
  input logic             mode_chg,
  input logic [TMR_W-1:0] tmr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o
);
  p_no_dead_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q || sel_q != 2'b00));

  p_hold_between_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !vs_rise) |=> $stable(count_o));

  p_latch_vsync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && vs_rise) |=> (count_o == $past(cnt)));

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  p_ovf_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !hsync_i) |=> !ovf_o);

  p_clr_keeps_cnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !hs_rise && !gate_end) |=> (cnt == $past(cnt)));

  p_timer_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> (tmr == '0));
endmodule

bind hsync_gate_counter hsync_gate_counter_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .ovf_clr_i(ovf_clr_i),
  .en_q(en_q), .sel_q(sel_q), .vs_rise(vs_rise), .hs_rise(hs_rise),
  .gate_end(gate_end), .mode_chg(mode_chg), .tmr(tmr), .cnt(cnt),
  .count_o(count_o), .ovf_o(ovf_o)
);

// File: tb/test_hsync_gate_counter.sv
module test_hsync_gate_counter;
  localparam int MAXC = 16383;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0, tick = 1'b0;
  logic we = 1'b0, en = 1'b0, clr = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [13:0] count;
  logic ovf, m_en;
  logic [1:0] m_sel;

  always #4 clk = ~clk;

  hsync_gate_counter i_hsync_gate_counter (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .vsync_i(vsync), .tick_i(tick),
    .ctrl_we_i(we), .ctrl_en_i(en), .ctrl_sel_i(sel), .ovf_clr_i(clr),
    .count_o(count), .ovf_o(ovf), .mode_en_o(m_en), .mode_sel_o(m_sel)
  );

  int n_chk = 0, n_bad = 0;
  int pend = 0, tick_cnt = 0, last = 0;
  bit exp_en = 1'b1;
  bit [1:0] exp_sel = 2'b01;
  int exp_q[$];
  string req_q[$];
  event latch_ev;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic push(input string req);
    last = (pend > MAXC) ? MAXC : pend;
    exp_q.push_back(last);
    req_q.push_back(req);
    -> latch_ev;
  endtask

  task automatic hs_pulse();
    @(negedge clk) hsync = 1'b1;
    pend++;
    @(negedge clk) hsync = 1'b0;
  endtask

  task automatic vs_edge(input string req, input bit with_hs);
    @(negedge clk);
    vsync = 1'b1;
    hsync = with_hs;
    if (exp_en) begin
      push(req);
      pend = with_hs ? 1 : 0;
    end else if (with_hs) pend++;
    @(negedge clk);
    vsync = 1'b0;
    hsync = 1'b0;
  endtask

  task automatic tick_period(input int n_hs, input string req);
    for (int i = 0; i < n_hs; i++) hs_pulse();
    repeat (7 - 2 * n_hs) @(negedge clk);
    @(negedge clk) tick = 1'b1;
    if (!exp_en) begin
      if (tick_cnt == (exp_sel[1] ? 31 : 15)) begin
        push(req);
        pend = 0;
        tick_cnt = 0;
      end else tick_cnt++;
    end
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic write_mode(input bit e, input bit [1:0] s);
    @(negedge clk);
    we = 1'b1; en = e; sel = s;
    if (e || s != 2'b00) begin
      if ({e, s} != {exp_en, exp_sel}) tick_cnt = 0;
      exp_en = e;
      exp_sel = s;
    end
    @(negedge clk) we = 1'b0;
  endtask

  task automatic clear_ovf();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  // monitor: compare latched results one cycle after each gate boundary
  initial begin
    forever begin
      @(latch_ev);
      @(negedge clk);
      if (exp_q.size() == 0) chk("scoreboard", 1, 0);
      else chk(req_q.pop_front(), int'(count), exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", int'(count), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 mode_en", int'(m_en), 1);
    chk("R1 mode_sel", int'(m_sel), 1);

    // R2 vsync-gated counting
    vs_edge("R2 first window", 1'b0);
    repeat (5) hs_pulse();
    vs_edge("R2 five edges", 1'b0);
    repeat (3) hs_pulse();
    chk("R2 hold mid-window", int'(count), 5);
    repeat (9) hs_pulse();
    vs_edge("R2 twelve edges", 1'b0);

    // R2 select ignored, ticks ignored
    write_mode(1'b1, 2'b10);
    chk("R2 sel stored", int'(m_sel), 2);
    for (int i = 0; i < 40; i++) tick_period(1, "R2 bad latch");
    chk("R2 ticks ignored", int'(count), 12);
    vs_edge("R2 forty edges", 1'b0);

    // R5 rejected write
    write_mode(1'b0, 2'b00);
    chk("R5 en kept", int'(m_en), 1);
    chk("R5 sel kept", int'(m_sel), 2);

    // R6 edge on boundary starts new window
    hs_pulse();
    vs_edge("R6 before", 1'b1);
    repeat (3) hs_pulse();
    vs_edge("R6 boundary edge counted", 1'b0);

    // R4 long window
    write_mode(1'b0, 2'b10);
    for (int i = 0; i < 32; i++) tick_period(2, "R4 long window");
    for (int i = 0; i < 31; i++) tick_period(1, "R4 early");
    chk("R4 hold before 32nd tick", int'(count), 64);
    tick_period(1, "R4 second long window");

    write_mode(1'b0, 2'b00);
    chk("R5 timed en kept", int'(m_en), 0);
    chk("R5 timed sel kept", int'(m_sel), 2);

    // R10 switch mid-window restarts timer, R3 short window
    for (int i = 0; i < 10; i++) tick_period(1, "R10 early");
    write_mode(1'b0, 2'b01);
    for (int i = 0; i < 15; i++) tick_period(2, "R10 early");
    chk("R10 no early latch", int'(count), 32);
    tick_period(2, "R10 full window after switch");
    for (int i = 0; i < 16; i++) tick_period(3, "R3 short window");

    // back to vsync gating
    write_mode(1'b1, 2'b01);
    vs_edge("R2 return", 1'b0);

    // R7 saturation and overflow, R8 sticky, R9 counter kept
    repeat (MAXC) hs_pulse();
    chk("R7 no ovf at max", int'(ovf), 0);
    repeat (7) hs_pulse();
    chk("R7 ovf set", int'(ovf), 1);
    vs_edge("R7 saturated count", 1'b0);
    chk("R8 ovf sticky", int'(ovf), 1);
    repeat (5) hs_pulse();
    clear_ovf();
    chk("R8 ovf cleared", int'(ovf), 0);
    repeat (5) hs_pulse();
    vs_edge("R9 count kept over clear", 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 ovf stays clear", int'(ovf), 0);
    finish_run();
  end
endmodule